// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Auto-Reload and Buffer Chaining

This block runs one DMA channel. The CPU sets it up through a small register write and read port. It can program a start address, a transfer count and a transfer mode. It can also program a second address and count pair, held in reserve as the next buffer. A transfer starts when the hardware request line is asserted or when software sets a request bit. Before any transfer, the channel asks the CPU for the system bus with a request and grant handshake. While it holds the grant, it issues one memory strobe per cycle and steps the address on each strobe.

When the count runs out, the channel has three choices:
- It can stop.
- It can reload its working address and count from the programmed base values and stay armed.
- It can switch to the reserved next buffer, which the CPU filled in while the previous buffer was still moving.

An interrupt pulse tells the CPU that a buffer has finished. In chaining mode, a pulse also tells the CPU that a new buffer has begun, so it can prepare the one after. If the reserve is empty when it is needed, the channel halts and reports an error.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Register map, by offset on `cfg_addr`:
  - 0 is the control register, read back with the software request bit in bit 6. Its fields are bit 0 enable, bits 2:1 mode, bit 3 auto-reload, bit 4 chaining, bit 5 address decrement and bit 6 software request. The mode field is 0 for single, 1 for block and 2 for demand; 3 behaves as block.
  - 1 is base address and 2 is base count. A write to either also loads the current value.
  - 3 is next address and 4 is next count. A write to 4 marks the next set valid.
  - 5 is status: bit 0 terminal count, bit 1 request pending, bit 2 chain error, bit 3 next valid, bit 4 busy.
  - 6 is current address and 7 is current count.
  - After reset, every register reads zero, and `bus_req`, `mem_stb` and `irq` are low.
- R2: `mem_stb` is asserted only while both `bus_req` and `bus_gnt` are high. After a bus tenure ends, `bus_req` stays low until `bus_gnt` has been removed.
- R3: Every strobe decrements the current count by one. Terminal count is the strobe issued while the count is zero, so a programmed N gives N+1 strobes. With neither auto-reload nor chaining set, the enable bit clears at terminal count and the current count reads all ones.
- R4: `mem_addr` is the current address. It steps by +1 per strobe, or by -1 when the decrement bit is set.
- R5: In single mode each bus tenure carries exactly one strobe. The channel then releases the bus, and it requests again while the request remains asserted.
- R6: In block mode one request starts a single tenure that carries every strobe up to terminal count, even if `hw_req` falls.
- R7: In demand mode strobes continue while `hw_req` stays high. When it falls the bus is released. A later request resumes from the address and count where the transfer stopped.
- R8: Writing control bit 6 starts a transfer as `hw_req` would. The bit clears itself at the first strobe, and status bit 1 then reads zero.
- R9: With auto-reload (and chaining clear), terminal count copies the base address and base count into the current registers, and the channel stays enabled.
- R10: With chaining set, terminal count with the next set valid does three things: it loads the next address and count, clears the valid bit, and keeps the channel enabled. Chaining takes priority over auto-reload. An `irq` pulse is also raised when a write turns the channel on with chaining set.
- R11: With chaining set and the next set not valid at terminal count, the channel clears enable, sets status bit 2 and issues no further strobes.
- R12: Status bit 0 is set by terminal count and cleared by reading status. If the read falls in the same cycle as a terminal count, the bit stays set.
- R13: `irq` is high for exactly one cycle in the cycle after each terminal-count strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (status read clears terminal count) |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data, combinational from `cfg_addr` |
| hw_req | input | 1 | Hardware transfer request |
| bus_req | output | 1 | System bus request to the CPU |
| bus_gnt | input | 1 | System bus grant from the CPU |
| mem_stb | output | 1 | One memory beat in this cycle |
| mem_addr | output | ADDR_W | Address of the current beat |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A status read clears the terminal-count flag, and a terminal-count strobe sets it. These two can land on the same clock edge. The bench provokes this by waiting, in single mode with a count of zero, for the cycle in which the only strobe is visible, and then issuing the status read in that cycle. The outcome is judged by a second status read, which must still see the flag set, followed by a third, which must see it cleared.

// File: rtl/dmac_pkg.sv
// dmac_pkg: shared encodings for the DMA channel sequencer.
// Assumes the configuration data width is at least 7 bits.
package dmac_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_DEMAND = 2'd2
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARB,
        SQ_MOVE,
        SQ_DROP
    } seq_state_e;

    typedef struct packed {
        logic       en;
        xfer_mode_e mode;
        logic       autold;
        logic       chain;
        logic       dec;
    } ctrl_t;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_BASE_A = 3'd1;
    localparam logic [2:0] RA_BASE_C = 3'd2;
    localparam logic [2:0] RA_NEXT_A = 3'd3;
    localparam logic [2:0] RA_NEXT_C = 3'd4;
    localparam logic [2:0] RA_STAT   = 3'd5;
    localparam logic [2:0] RA_CUR_A  = 3'd6;
    localparam logic [2:0] RA_CUR_C  = 3'd7;

    localparam int CB_EN    = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_AUTO  = 3;
    localparam int CB_CHAIN = 4;
    localparam int CB_DEC   = 5;
    localparam int CB_SWREQ = 6;

    localparam int SB_TC    = 0;
    localparam int SB_PEND  = 1;
    localparam int SB_ERR   = 2;
    localparam int SB_NVAL  = 3;
    localparam int SB_BUSY  = 4;

endpackage

// File: rtl/dmac_regs.sv
// dmac_regs: programmable register file of the DMA channel.
// Holds control, base and next-buffer registers plus status flags, and
// drives the read mux and the interrupt pulse.
// Assumes ADDR_W >= 7 and CNT_W <= ADDR_W. Event inputs from the
// sequencer are single-cycle pulses.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [2:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              hw_req,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              busy,
    input  logic              beat,
    input  logic              tc_evt,
    input  logic              chain_take,
    input  logic              chain_fail,
    input  logic              halt,
    output ctrl_t             ctrl,
    output logic              sw_pend,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  base_cnt,
    output logic [ADDR_W-1:0] next_addr,
    output logic [CNT_W-1:0]  next_cnt,
    output logic              next_valid,
    output logic              err_flag,
    output logic              ld_cur_addr,
    output logic              ld_cur_cnt,
    output logic              irq
);

    logic wr_ctrl, wr_next_c, rd_stat, tc_flag, chain_on;

    assign wr_ctrl     = cfg_we && (cfg_addr == RA_CTRL);
    assign ld_cur_addr = cfg_we && (cfg_addr == RA_BASE_A);
    assign ld_cur_cnt  = cfg_we && (cfg_addr == RA_BASE_C);
    assign wr_next_c   = cfg_we && (cfg_addr == RA_NEXT_C);
    assign rd_stat     = cfg_re && (cfg_addr == RA_STAT);
    assign chain_on    = wr_ctrl && cfg_wdata[CB_EN] && cfg_wdata[CB_CHAIN] && !ctrl.en;

    // Control register: CPU write wins over a sequencer halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.en     <= cfg_wdata[CB_EN];
            ctrl.mode   <= xfer_mode_e'(cfg_wdata[CB_MODE +: 2]);
            ctrl.autold <= cfg_wdata[CB_AUTO];
            ctrl.chain  <= cfg_wdata[CB_CHAIN];
            ctrl.dec    <= cfg_wdata[CB_DEC];
        end else if (halt) begin
            ctrl.en <= 1'b0;
        end
    end

    // Software request: a new write sets it, the first beat clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sw_pend <= 1'b0;
        else if (wr_ctrl && cfg_wdata[CB_SWREQ]) sw_pend <= 1'b1;
        else if (beat)                           sw_pend <= 1'b0;
    end

    // Base and next-buffer address/count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            next_addr <= '0;
            next_cnt  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                RA_BASE_A: base_addr <= cfg_wdata;
                RA_BASE_C: base_cnt  <= cfg_wdata[CNT_W-1:0];
                RA_NEXT_A: next_addr <= cfg_wdata;
                RA_NEXT_C: next_cnt  <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Next-set valid flag: set by the count write, consumed by a chain switch.
    always_ff @(posedge clk) begin
        if (!rst_n)          next_valid <= 1'b0;
        else if (wr_next_c)  next_valid <= 1'b1;
        else if (chain_take) next_valid <= 1'b0;
    end

    // Terminal-count flag: a new terminal count wins over a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       tc_flag <= 1'b0;
        else if (tc_evt)  tc_flag <= 1'b1;
        else if (rd_stat) tc_flag <= 1'b0;
    end

    // Chain error flag: set on a missing next set, cleared by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_flag <= 1'b0;
        else if (chain_fail) err_flag <= 1'b1;
        else if (wr_ctrl)    err_flag <= 1'b0;
    end

    // Interrupt pulse: terminal count, or chaining channel switched on.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= tc_evt || chain_on;
    end

    // Read mux, zero-extended to the port width.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_CTRL:   cfg_rdata[6:0] = {sw_pend, ctrl.dec, ctrl.chain, ctrl.autold,
                                         ctrl.mode, ctrl.en};
            RA_BASE_A: cfg_rdata = base_addr;
            RA_BASE_C: cfg_rdata[CNT_W-1:0] = base_cnt;
            RA_NEXT_A: cfg_rdata = next_addr;
            RA_NEXT_C: cfg_rdata[CNT_W-1:0] = next_cnt;
            RA_STAT:   cfg_rdata[SB_BUSY:0] = {busy, next_valid, err_flag,
                                               hw_req || sw_pend, tc_flag};
            RA_CUR_A:  cfg_rdata = cur_addr;
            default:   cfg_rdata[CNT_W-1:0] = cur_cnt;
        endcase
    end

endmodule

// File: rtl/dmac_seq.sv
// dmac_seq: transfer sequencer. Runs the bus handshake, issues one beat
// per granted cycle and steps the current address and count. At
// terminal count it reloads, chains or halts.
// Assumes the grant is not removed while the request is still held.
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic              sw_pend,
    input  logic              hw_req,
    input  logic              bus_gnt,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  base_cnt,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [CNT_W-1:0]  next_cnt,
    input  logic              next_valid,
    input  logic              ld_cur_addr,
    input  logic              ld_cur_cnt,
    input  logic [ADDR_W-1:0] wval,
    output logic              bus_req,
    output logic              mem_stb,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              busy,
    output logic              beat,
    output logic              tc_evt,
    output logic              chain_take,
    output logic              chain_fail,
    output logic              halt
);

    seq_state_e state, nxt;
    logic trigger, last, reload;

    assign trigger    = ctrl.en && (hw_req || sw_pend);
    assign beat       = (state == SQ_MOVE) && bus_gnt;
    assign last       = beat && (cur_cnt == '0);
    assign tc_evt     = last;
    assign chain_take = last && ctrl.chain && next_valid;
    assign chain_fail = last && ctrl.chain && !next_valid;
    assign reload     = last && !ctrl.chain && ctrl.autold;
    assign halt       = last && (ctrl.chain ? !next_valid : !ctrl.autold);
    assign bus_req    = (state == SQ_ARB) || (state == SQ_MOVE);
    assign mem_stb    = beat;
    assign busy       = (state != SQ_IDLE);

    // Next-state decode for the bus tenure.
    always_comb begin
        nxt = state;
        case (state)
            SQ_IDLE: if (trigger) nxt = SQ_ARB;
            SQ_ARB:  if (bus_gnt) nxt = SQ_MOVE;
            SQ_MOVE: begin
                if (beat) begin
                    if (last) nxt = SQ_DROP;
                    else begin
                        case (ctrl.mode)
                            XM_SINGLE: nxt = SQ_DROP;
                            XM_DEMAND: if (!hw_req) nxt = SQ_DROP;
                            default:   nxt = SQ_MOVE;
                        endcase
                    end
                end
            end
            default: if (!bus_gnt) nxt = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    // Current address: CPU load, chain switch, reload, then per-beat step.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_addr <= '0;
        else if (ld_cur_addr) cur_addr <= wval;
        else if (chain_take) cur_addr <= next_addr;
        else if (reload)     cur_addr <= base_addr;
        else if (beat)       cur_addr <= ctrl.dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
    end

    // Current count: same priority, decremented per beat (wraps at terminal count).
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_cnt <= '0;
        else if (ld_cur_cnt) cur_cnt <= wval[CNT_W-1:0];
        else if (chain_take) cur_cnt <= next_cnt;
        else if (reload)     cur_cnt <= base_cnt;
        else if (beat)       cur_cnt <= cur_cnt - 1'b1;
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
// dma_chan_ctrl: top of a single DMA channel with auto-reload and
// next-buffer chaining. Connects the register file to the sequencer.
// Assumes ADDR_W >= 7 and CNT_W <= ADDR_W.
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [2:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              hw_req,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_stb,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              irq
);

    ctrl_t             ctrl;
    logic              sw_pend, next_valid, err_flag, ld_cur_addr, ld_cur_cnt;
    logic              busy, beat, tc_evt, chain_take, chain_fail, halt;
    logic [ADDR_W-1:0] base_addr, next_addr, cur_addr;
    logic [CNT_W-1:0]  base_cnt, next_cnt, cur_cnt;

    assign mem_addr = cur_addr;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .hw_req(hw_req), .cur_addr(cur_addr), .cur_cnt(cur_cnt), .busy(busy),
        .beat(beat), .tc_evt(tc_evt), .chain_take(chain_take),
        .chain_fail(chain_fail), .halt(halt), .ctrl(ctrl), .sw_pend(sw_pend),
        .base_addr(base_addr), .base_cnt(base_cnt), .next_addr(next_addr),
        .next_cnt(next_cnt), .next_valid(next_valid), .err_flag(err_flag),
        .ld_cur_addr(ld_cur_addr), .ld_cur_cnt(ld_cur_cnt), .irq(irq)
    );

    dmac_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sw_pend(sw_pend),
        .hw_req(hw_req), .bus_gnt(bus_gnt), .base_addr(base_addr),
        .base_cnt(base_cnt), .next_addr(next_addr), .next_cnt(next_cnt),
        .next_valid(next_valid), .ld_cur_addr(ld_cur_addr),
        .ld_cur_cnt(ld_cur_cnt), .wval(cfg_wdata), .bus_req(bus_req),
        .mem_stb(mem_stb), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .busy(busy), .beat(beat), .tc_evt(tc_evt), .chain_take(chain_take),
        .chain_fail(chain_fail), .halt(halt)
    );

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
// dma_chan_ctrl_chk: protocol and sequencing properties of the DMA
// channel, bound into every dma_chan_ctrl instance.
module dma_chan_ctrl_chk
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_stb,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input ctrl_t             ctrl,
    input logic              err_flag,
    input logic              irq
);

    // R2: a beat needs both request and grant.
    p_stb_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> (bus_req && bus_gnt));

    // R4: non-terminal beat steps the address by one in the chosen direction.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && cur_cnt != '0 && !cfg_we) |=>
        (mem_addr == ($past(ctrl.dec) ? $past(mem_addr) - 1'b1 : $past(mem_addr) + 1'b1)));

    // R3: non-terminal beat decrements the count.
    p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && cur_cnt != '0 && !cfg_we) |=> (cur_cnt == $past(cur_cnt) - 1'b1));

    // R5: single mode never issues two beats back to back.
    p_single_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && ctrl.mode == XM_SINGLE) |=> !mem_stb);

    // R13: terminal-count beat is followed by the interrupt pulse.
    p_irq_tc_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && cur_cnt == '0) |=> irq);

    // R11: a chain error leaves the channel disabled.
    p_fail_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err_flag) && !$past(cfg_we)) |-> !ctrl.en);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_stb(mem_stb), .mem_addr(mem_addr),
    .cur_cnt(cur_cnt), .ctrl(ctrl), .err_flag(err_flag), .irq(irq)
);

// File: tb/dma_chan_ctrl_bench.sv
// Directed bench for dma_chan_ctrl: one task per scenario.
module dma_chan_ctrl_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_re = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          hw_req = 1'b0;
    logic          bus_req, bus_gnt = 1'b0, mem_stb, irq;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    int nb = 0, tenures = 0, irqs = 0;
    int gnt_mode = 0;
    logic [AW-1:0] alog [0:63];
    logic prev_req = 1'b0;

    always #4 clk = ~clk;

    dma_chan_ctrl u_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .hw_req(hw_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_stb(mem_stb), .mem_addr(mem_addr), .irq(irq)
    );

    // CPU bus model: grant follows request one cycle later unless forced.
    initial forever begin
        @(posedge clk);
        if (gnt_mode == 1)      bus_gnt <= 1'b0;
        else if (gnt_mode == 2) bus_gnt <= 1'b1;
        else                    bus_gnt <= bus_req;
    end

    // Observer: beat log, tenure count, interrupt count.
    initial forever begin
        @(negedge clk);
        if (mem_stb === 1'b1) begin
            if (nb < 64) alog[nb] = mem_addr;
            nb++;
        end
        if (bus_req === 1'b1 && !prev_req) tenures++;
        prev_req = bus_req;
        if (irq === 1'b1) irqs++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        nb = 0; tenures = 0; irqs = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
        cfg_re = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        chk("R1 bus_req after reset", bus_req, 0);
        chk("R1 mem_stb after reset", mem_stb, 0);
        chk("R1 irq after reset", irq, 0);
        rd(3'd0, v); chk("R1 control after reset", v, 0);
        rd(3'd5, v); chk("R1 status after reset", v, 0);
    endtask

    task automatic t_block();
        logic [AW-1:0] v;
        clr_log();
        wr(3'd1, 16'h0100); wr(3'd2, 16'd3); wr(3'd0, 16'h0003);
        hw_req = 1'b1; @(negedge clk); hw_req = 1'b0;
        idle(30);
        chk("R3 block beat count", nb, 4);
        for (int i = 0; i < 4; i++) chk("R4 block ascending address", alog[i], 16'h0100 + i);
        chk("R6 block single tenure", tenures, 1);
        chk("R13 one irq per terminal count", irqs, 1);
        rd(3'd7, v); chk("R3 count wraps to all ones", v, 16'h00FF);
        rd(3'd0, v); chk("R3 enable cleared at terminal count", v[0], 0);
        rd(3'd5, v); chk("R12 tc flag set", v[0], 1);
        rd(3'd5, v); chk("R12 tc flag cleared by read", v[0], 0);
    endtask

    task automatic t_dec_sw();
        logic [AW-1:0] v;
        clr_log();
        wr(3'd1, 16'h0200); wr(3'd2, 16'd2); wr(3'd0, 16'h0063);
        idle(30);
        chk("R8 software request beats", nb, 3);
        for (int i = 0; i < 3; i++) chk("R4 decrement address", alog[i], 16'h0200 - i);
        rd(3'd5, v); chk("R8 request pending clears", v[1], 0);
    endtask

    task automatic t_single();
        clr_log();
        wr(3'd1, 16'h0300); wr(3'd2, 16'd2); wr(3'd0, 16'h0001);
        hw_req = 1'b1; idle(40); hw_req = 1'b0; idle(5);
        chk("R5 single beats", nb, 3);
        chk("R5 one tenure per beat", tenures, 3);
        chk("R5 single last address", alog[2], 16'h0302);
    endtask

    task automatic t_demand();
        int b1;
        clr_log();
        wr(3'd1, 16'h0400); wr(3'd2, 16'd7); wr(3'd0, 16'h0005);
        hw_req = 1'b1; idle(7); hw_req = 1'b0; idle(6);
        b1 = nb;
        chk("R7 demand paused part way", (b1 > 0 && b1 < 8), 1);
        idle(10);
        chk("R7 no beats while request low", nb, b1);
        hw_req = 1'b1; idle(30); hw_req = 1'b0; idle(4);
        chk("R7 demand total beats", nb, 8);
        chk("R7 demand tenures", tenures, 2);
        for (int i = 0; i < 8; i++) chk("R7 demand resumes address", alog[i], 16'h0400 + i);
    endtask

    task automatic t_auto();
        logic [AW-1:0] v;
        clr_log();
        wr(3'd1, 16'h0500); wr(3'd2, 16'd1); wr(3'd0, 16'h004B);
        idle(25);
        chk("R9 first pass beats", nb, 2);
        rd(3'd0, v); chk("R9 stays enabled", v[0], 1);
        rd(3'd6, v); chk("R9 address reloaded", v, 16'h0500);
        rd(3'd7, v); chk("R9 count reloaded", v, 16'd1);
        wr(3'd0, 16'h004B); idle(25);
        chk("R9 second pass beats", nb, 4);
        chk("R9 second pass address", alog[2], 16'h0500);
        wr(3'd0, 16'h0000);
        rd(3'd5, v);
    endtask

    task automatic t_chain();
        logic [AW-1:0] v;
        clr_log();
        wr(3'd1, 16'h0600); wr(3'd2, 16'd1); wr(3'd0, 16'h001B);
        idle(3);
        chk("R10 irq on chain enable", irqs, 1);
        wr(3'd3, 16'h0700); wr(3'd4, 16'd0);
        rd(3'd5, v); chk("R10 next valid set", v[3], 1);
        wr(3'd0, 16'h005B); idle(25);
        chk("R10 first buffer beats", nb, 2);
        rd(3'd5, v); chk("R10 next valid consumed", v[3], 0);
        rd(3'd6, v); chk("R10 chain over reload address", v, 16'h0700);
        rd(3'd0, v); chk("R10 enabled after switch", v[0], 1);
        wr(3'd0, 16'h005B); idle(25);
        chk("R10 second buffer beat", nb, 3);
        chk("R10 second buffer address", alog[2], 16'h0700);
        rd(3'd5, v); chk("R11 chain error flag", v[2], 1);
        rd(3'd0, v); chk("R11 enable cleared", v[0], 0);
        hw_req = 1'b1; idle(15); hw_req = 1'b0;
        chk("R11 no beats after error", nb, 3);
        chk("R13 chain irqs", irqs, 3);
    endtask

    task automatic t_grant();
        clr_log();
        gnt_mode = 1;
        wr(3'd1, 16'h0900); wr(3'd2, 16'd1); wr(3'd0, 16'h0001);
        hw_req = 1'b1; idle(10);
        chk("R2 request held without grant", bus_req, 1);
        chk("R2 no beat without grant", nb, 0);
        gnt_mode = 0;
        while (nb == 0) @(negedge clk);
        gnt_mode = 2;
        idle(8);
        chk("R2 no re-request while grant held", bus_req, 0);
        chk("R2 one beat while grant held", nb, 1);
        gnt_mode = 0; idle(20); hw_req = 1'b0;
        chk("R2 resumes after grant removed", nb, 2);
    endtask

    task automatic t_race();
        logic [AW-1:0] v;
        clr_log();
        rd(3'd5, v);
        wr(3'd1, 16'h0800); wr(3'd2, 16'd0); wr(3'd0, 16'h0001);
        hw_req = 1'b1;
        while (mem_stb !== 1'b1) @(negedge clk);
        cfg_re = 1'b1; cfg_addr = 3'd5;
        @(negedge clk);
        cfg_re = 1'b0; hw_req = 1'b0;
        rd(3'd5, v); chk("R12 set wins over same-cycle read", v[0], 1);
        rd(3'd5, v); chk("R12 cleared by later read", v[0], 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_block();
        t_dec_sw();
        t_single();
        t_demand();
        t_auto();
        t_chain();
        t_grant();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule